// File: doc/BRIEF.md
# Multiplexed Address/Data Memory Port

This block is the device-side front end of a memory reached over a shared 16-bit bus that carries first an address and then data. The high part of the word address arrives on dedicated pins. The low 16 bits arrive on the shared bus and are caught under control of an active-low address strobe. Once the address is held, the same bus either returns the stored word or brings in a word to be written. A small internal word array stands in for the storage, so the front end can be exercised alone.

Two capture styles are offered. In clocked mode, the first clock edge that sees the strobe low closes the latch, and read data is released a fixed number of clock edges later. In flow-through mode, the latch follows the bus on every edge for as long as the strobe is low, and the data phase opens on the first edge that sees the strobe high again. Chip select, output enable and reset all gate the bus driver. Asserting the strobe again while data is moving is flagged as a protocol fault.

All control inputs are sampled on `clk`. The bus is split into `dq_in`, `dq_out` and a driver enable `dq_oe`, which the pad ring combines into one bidirectional pin group.

Top module: `admux_mem_port`

## Requirements
- R1: While `rst_n` is low, `dq_oe` and `proto_err` are 0 whatever the other inputs do, and the port returns to idle.
- R2: With `ce_n` high, `dq_oe` is 0 at once, and the current access is abandoned: when `ce_n` is lowered again without a new strobe, `dq_oe` stays 0.
- R3: With `oe_n` high, `dq_oe` is 0 even during a ready data phase; lowering `oe_n` again restores the drive without any new access.
- R4: The full word address is {`addr_hi`, low address from `dq_in`}, with bit 0 the lowest word. The array holds 2^ARRAY_AW words selected by address bits [ARRAY_AW-1:0]; higher bits alias.
- R5: In clocked mode (`sync_mode`=1), the address is taken at the first rising clock edge that samples `adv_n` low with `ce_n` low from idle. Later values on `dq_in` do not change it.
- R6: In clocked mode, `dq_oe` stays 0 through the first LATENCY-1 edges after the capture edge and becomes 1 (with `oe_n` low) after the LATENCY-th edge, with `dq_out` carrying the addressed word.
- R7: In flow-through mode (`sync_mode`=0), the latch loads the bus on every edge that samples `adv_n` low. The last such value is the address. The data phase, and with it `dq_oe`, begins after the first edge that samples `adv_n` high.
- R8: An edge that samples `adv_n` low during the data phase with `ce_n` low raises `proto_err` for the following cycle, and leaves the latched address unchanged.
- R9: A write happens at an edge that samples `we_n` high when the previous edge sampled it low, during the data phase with `ce_n` low. It stores the `dq_in` value sampled at that edge into the latched address.
- R10: A rising `we_n` while `rst_n` is low writes nothing.
- R11: When `dq_oe` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sync_mode | input | 1 | 1 = clocked capture, 0 = flow-through capture |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe, acts on its rising edge |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr_hi | input | UPPER_W | High word-address bits |
| dq_in | input | DQ_W | Shared bus, inbound: low address, then write data |
| dq_out | output | DQ_W | Shared bus, outbound read data |
| dq_oe | output | 1 | Bus driver enable |
| proto_err | output | 1 | Strobe asserted during the data phase |

## Verification
The hardest case to reach is a strobe fault in the middle of a clocked read. The fault must land after the capture edge but before the latency count has run out, and it must carry a different address on the bus, so that a latch that wrongly reopened would show up in the returned word. The bench captures one address, lets one edge pass with the strobe high, and then pulls the strobe low with another address on `dq_in`. It then waits out the latency and checks both the fault flag and the returned word. A write interrupted by reset is reached the same way: a write strobe is held low inside a data phase, and reset is asserted before the strobe rises.

// File: rtl/admux_pkg.sv
package admux_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPEN = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Rising edge of a sampled level: low on the previous edge, high now.
  function automatic logic level_rose(input logic prev, input logic now);
    return now & ~prev;
  endfunction

  // Latency down-counter step, saturating at zero.
  function automatic int unsigned count_step(input int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

endpackage

// File: rtl/admux_addr_latch.sv
module admux_addr_latch
  import admux_pkg::*;
#(
  parameter int UPPER_W = 4,
  parameter int DQ_W    = 16,
  parameter int LATENCY = 2,
  localparam int ADDR_W = UPPER_W + DQ_W,
  localparam int CNT_W  = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              sync_mode,
  input  logic [UPPER_W-1:0] addr_hi,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              in_data,
  output logic              rd_ready,
  output logic              cap_evt,
  output logic              adv_viol
);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic              sel;
  logic              async_load;
  logic              close_evt;
  logic [ADDR_W-1:0] bus_addr;

  assign sel        = ~ce_n;
  assign bus_addr   = {addr_hi, dq_in};
  assign cap_evt    = sel & ~adv_n & (ph == PH_IDLE) & sync_mode;
  assign async_load = sel & ~adv_n &
                      (((ph == PH_IDLE) & ~sync_mode) | (ph == PH_OPEN));
  assign close_evt  = sel & adv_n & (ph == PH_OPEN);
  assign adv_viol   = sel & ~adv_n & (ph == PH_DATA);
  assign in_data    = (ph == PH_DATA);
  assign rd_ready   = in_data & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      lat_addr <= '0;
    end else if (!sel) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (cap_evt) begin
      lat_addr <= bus_addr;
      ph       <= PH_DATA;
      cnt      <= CNT_W'(LATENCY);
    end else if (async_load) begin
      lat_addr <= bus_addr;
      ph       <= PH_OPEN;
    end else if (close_evt) begin
      ph  <= PH_DATA;
      cnt <= '0;
    end else if (in_data) begin
      cnt <= CNT_W'(count_step(int'(cnt)));
    end
  end

endmodule

// File: rtl/admux_word_store.sv
module admux_word_store #(
  parameter int DQ_W     = 16,
  parameter int ARRAY_AW = 6,
  localparam int DEPTH   = 1 << ARRAY_AW
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ARRAY_AW-1:0] idx,
  input  logic [DQ_W-1:0]     wdata,
  output logic [DQ_W-1:0]     rdata
);

  logic [DQ_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/admux_bus_ctrl.sv
module admux_bus_ctrl
  import admux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic in_data,
  input  logic rd_ready,
  input  logic adv_viol,
  output logic dq_oe,
  output logic wr_en,
  output logic proto_err
);

  logic we_q;

  assign dq_oe = ~ce_n & ~oe_n & rst_n & rd_ready;
  assign wr_en = rst_n & ~ce_n & in_data & level_rose(we_q, we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      proto_err <= 1'b0;
    end else begin
      we_q      <= we_n;
      proto_err <= adv_viol;
    end
  end

endmodule

// File: rtl/admux_mem_port.sv
module admux_mem_port #(
  parameter int UPPER_W  = 4,
  parameter int DQ_W     = 16,
  parameter int ARRAY_AW = 6,
  parameter int LATENCY  = 2,
  localparam int ADDR_W  = UPPER_W + DQ_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_mode,
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic               adv_n,
  input  logic [UPPER_W-1:0] addr_hi,
  input  logic [DQ_W-1:0]    dq_in,
  output logic [DQ_W-1:0]    dq_out,
  output logic               dq_oe,
  output logic               proto_err
);

  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0]   lat_addr;
  logic                in_data;
  logic                rd_ready;
  logic                cap_evt;
  logic                adv_viol;
  logic                wr_en;
  logic [DQ_W-1:0]     rdata;
  logic [ARRAY_AW-1:0] widx;

  function automatic logic [ARRAY_AW-1:0] word_idx(input logic [ADDR_W-1:0] a);
    return a[ARRAY_AW-1:0];
  endfunction

  assign widx = word_idx(lat_addr);

  admux_addr_latch #(
    .UPPER_W (UPPER_W),
    .DQ_W    (DQ_W),
    .LATENCY (LATENCY)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .adv_n     (adv_n),
    .sync_mode (sync_mode),
    .addr_hi   (addr_hi),
    .dq_in     (dq_in),
    .lat_addr  (lat_addr),
    .in_data   (in_data),
    .rd_ready  (rd_ready),
    .cap_evt   (cap_evt),
    .adv_viol  (adv_viol)
  );

  admux_bus_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .in_data   (in_data),
    .rd_ready  (rd_ready),
    .adv_viol  (adv_viol),
    .dq_oe     (dq_oe),
    .wr_en     (wr_en),
    .proto_err (proto_err)
  );

  admux_word_store #(
    .DQ_W     (DQ_W),
    .ARRAY_AW (ARRAY_AW)
  ) u_store (
    .clk   (clk),
    .wr_en (wr_en),
    .idx   (widx),
    .wdata (dq_in),
    .rdata (rdata)
  );

  assign dq_out = dq_oe ? rdata : '0;

endmodule

// File: rtl/admux_port_chk.sv
module admux_port_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              proto_err,
  input logic              cap_evt,
  input logic              in_data,
  input logic              rd_ready,
  input logic              adv_viol,
  input logic [ADDR_W-1:0] lat_addr
);

  always_comb begin
    if (rst_n === 1'b0) begin
      p_reset_quiet_r1: assert (!dq_oe && !proto_err)
        else $error("driver or fault flag active in reset");
    end
  end

  p_deselect_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  p_sync_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !rd_ready);

  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_viol |=> proto_err);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |=> (!in_data || $stable(lat_addr)));

endmodule

bind admux_mem_port admux_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .dq_oe     (dq_oe),
  .proto_err (proto_err),
  .cap_evt   (cap_evt),
  .in_data   (in_data),
  .rd_ready  (rd_ready),
  .adv_viol  (adv_viol),
  .lat_addr  (lat_addr)
);

// File: tb/tb_admux_mem_port.sv
`timescale 1ns/1ps
module tb_admux_mem_port;
  localparam int UW  = 4;
  localparam int DW  = 16;
  localparam int AW  = 6;
  localparam int LAT = 2;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, sync_mode, ce_n, oe_n, we_n, adv_n;
  logic [UW-1:0] addr_hi;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe, proto_err;

  admux_mem_port #(.UPPER_W(UW), .DQ_W(DW), .ARRAY_AW(AW), .LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .adv_n(adv_n), .addr_hi(addr_hi), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .proto_err(proto_err)
  );

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [DW-1:0] ref_mem [NW];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int salt);
    return DW'((i * 16'h0107) ^ salt ^ (i << 10));
  endfunction

  // Low address with junk above the array index bits (R4 aliasing).
  function automatic logic [DW-1:0] low_of(input int i, input int junk);
    return DW'(i) | DW'((junk * 37) << AW);
  endfunction

  task automatic sync_access(input logic [UW-1:0] hi, input logic [DW-1:0] lo,
                             input logic is_wr, input logic [DW-1:0] wdat);
    sync_mode = 1'b1; ce_n = 1'b0; oe_n = is_wr; we_n = 1'b1;
    addr_hi = hi; dq_in = lo; adv_n = 1'b0;
    tick();                               // capture edge
    adv_n = 1'b1; dq_in = ~lo;            // R5: later bus values ignored
    if (is_wr) begin
      dq_in = wdat; we_n = 1'b0; tick();
      we_n = 1'b1; tick();                // R9 write edge
      ref_mem[lo[AW-1:0]] = wdat;
    end else begin
      for (int k = 0; k < LAT; k++) begin
        #1 check("R6 no drive before latency", 32'(dq_oe), 32'd0);
        check("R11 idle bus zero", 32'(dq_out), 32'd0);
        tick();
      end
      #1 check("R6 drive after latency", 32'(dq_oe), 32'd1);
      check("R4 R5 sync read data", 32'(dq_out), 32'(ref_mem[lo[AW-1:0]]));
    end
    ce_n = 1'b1; tick();
  endtask

  task automatic async_access(input logic [UW-1:0] hi, input logic [DW-1:0] lo,
                              input logic is_wr, input logic [DW-1:0] wdat);
    sync_mode = 1'b0; ce_n = 1'b0; oe_n = is_wr; we_n = 1'b1;
    addr_hi = hi; dq_in = 16'hDEAD; adv_n = 1'b0;
    tick();                               // latch follows junk
    dq_in = lo; tick();                   // latch follows address
    adv_n = 1'b1; dq_in = is_wr ? wdat : 16'h5A5A;
    #1 check("R7 no drive while latch open", 32'(dq_oe), 32'd0);
    tick();                               // data phase opens
    if (is_wr) begin
      we_n = 1'b0; tick();
      we_n = 1'b1; tick();                // R9 write edge
      ref_mem[lo[AW-1:0]] = wdat;
    end else begin
      #1 check("R7 drive at data phase", 32'(dq_oe), 32'd1);
      check("R7 R4 async read data", 32'(dq_out), 32'(ref_mem[lo[AW-1:0]]));
    end
    ce_n = 1'b1; tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_mode = 1'b1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    adv_n = 1'b0; addr_hi = '0; dq_in = '0;
    tick(); tick();
    // R1: reset holds everything quiet despite an active request
    check("R1 no drive in reset", 32'(dq_oe), 32'd0);
    check("R1 no fault in reset", 32'(proto_err), 32'd0);
    ce_n = 1'b1; adv_n = 1'b1;
    rst_n = 1'b1; tick();

    // Fill the whole array in clocked mode, varying high bits (R4, R9)
    for (int i = 0; i < NW; i++)
      sync_access(UW'(i ^ 9), low_of(i, i), 1'b1, pat(i, 16'hA5C3));
    // Read back in flow-through mode with other alias bits (R4, R7)
    for (int i = 0; i < NW; i++)
      async_access(UW'(i + 3), low_of(i, i + 11), 1'b0, '0);
    // Overwrite even words in flow-through mode, read all in clocked mode
    for (int i = 0; i < NW; i += 2)
      async_access(UW'(i), low_of(i, 5), 1'b1, pat(i, 16'h3C96));
    for (int i = 0; i < NW; i++)
      sync_access(UW'(15 - (i % 16)), low_of(i, i * 3), 1'b0, '0);

    // R8: strobe during the clocked data phase with another address on the bus
    sync_mode = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr_hi = 4'h2;
    dq_in = low_of(5, 1); adv_n = 1'b0; tick();
    adv_n = 1'b1; dq_in = '0; tick();
    adv_n = 1'b0; dq_in = low_of(9, 2); tick();
    check("R8 fault flagged", 32'(proto_err), 32'd1);
    adv_n = 1'b1;
    for (int k = 0; k < LAT; k++) tick();
    check("R8 fault clears", 32'(proto_err), 32'd0);
    check("R8 drive after fault", 32'(dq_oe), 32'd1);
    check("R8 address unchanged", 32'(dq_out), 32'(ref_mem[5]));

    // R3: output enable gating within a ready data phase
    oe_n = 1'b1; #1 check("R3 oe high blocks drive", 32'(dq_oe), 32'd0);
    check("R11 zero when blocked", 32'(dq_out), 32'd0);
    oe_n = 1'b0; #1 check("R3 oe low restores drive", 32'(dq_oe), 32'd1);

    // R2: deselect aborts; reselect alone does not resume
    ce_n = 1'b1; #1 check("R2 deselect blocks drive", 32'(dq_oe), 32'd0);
    tick();
    ce_n = 1'b0; #1 check("R2 no resume on reselect", 32'(dq_oe), 32'd0);
    tick(); check("R2 still idle", 32'(dq_oe), 32'd0);
    ce_n = 1'b1; tick();

    // R10: write strobe rises during reset -> no write
    sync_mode = 1'b1; ce_n = 1'b0; oe_n = 1'b1; addr_hi = 4'h0;
    dq_in = low_of(7, 4); adv_n = 1'b0; tick();
    adv_n = 1'b1; dq_in = 16'hBEEF; we_n = 1'b0; tick();
    rst_n = 1'b0; #1 we_n = 1'b1; tick(); tick();
    check("R1 no drive in reset", 32'(dq_oe), 32'd0);
    ce_n = 1'b1; rst_n = 1'b1; tick();
    sync_access(4'h6, low_of(7, 9), 1'b0, '0);   // R10: word 7 unchanged

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule